// File: doc/BRIEF.md
# Endpoint Response Control and Handshake Selection

This block holds the response settings of one USB device endpoint and uses them to pick the handshake for each transaction the host starts. Software changes the 8-bit control word through two write ports, one that sets the bits marked with a 1 and one that clears them. The current word is always visible on a read port. The hardware also changes some bits on its own. It raises the status-phase hold and clears halt when a setup packet arrives on a control endpoint. It latches the NAK-OUT bit after a short OUT packet. It moves the data toggle as transfers complete.

Each transaction arrives as one beat on a token stream. The beat carries the token kind, a status-phase marker, a short-packet flag and an error flag. For IN, the error flag means the host did not acknowledge. For OUT, it means the packet was corrupt. The buffer state comes in on plain pins. The block answers with one beat on a response stream, which carries the handshake code and the data PID parity. It also records the outcome in six write-1-to-clear status bits and pulses data-received or data-transmitted indications. Token checks, the transceiver and the packet memory sit outside.

Top module: `ep_rsp_ctrl`

## Requirements
- R1: The control word resets to 0x20 and reads back on `ctl_q`. Bit 7 is the NAK-OUT latch, bit 6 hides the status phase, bit 5 is auto-validate, bit 4 is interrupt-feedback mode, bit 3 holds the status phase, bit 2 is NAK-OUT mode, bit 1 is the data toggle and bit 0 is halt. A 1 on the set port sets the bit and a 1 on the clear port clears it. When both ports hit the same bit in the same cycle, the set wins. A hardware update in the same cycle overrides both.
- R2: While halt is set, every non-setup token gets STALL (code 2) and status bit 5 (stall sent) is set.
- R3: A setup token (kind 0) always gets ACK (code 0), sets status bit 1 and forces the toggle to 1. On endpoint 0 it also sets the status-phase hold and clears halt.
- R4: A status-phase token gets NAK (code 1) while the hold bit is set. IN sets status bit 4 and OUT sets status bit 2. With the hold clear, a status OUT (kind 1) gets ACK and a status IN (kind 2) gets a zero-length packet (code 3) with PID parity 1.
- R5: An IN data token gets a data packet (code 4) carrying the current toggle as PID parity when the buffer is committed, or when auto-validate is set and the buffer holds a full packet. Otherwise it gets NAK and status bit 4 is set.
- R6: After an IN data packet, the toggle flips when the host acknowledges, and status bit 3 is set. When the host does not acknowledge, status bit 0 (timeout) is set and the toggle holds, unless interrupt-feedback mode is on, in which case it flips anyway. An acknowledged OUT data packet also flips the toggle.
- R7: An OUT data token gets NAK and sets status bit 2 when the NAK-OUT latch is set or the buffer is full. A corrupt packet gets no handshake (code 5) and sets status bit 0. Otherwise the token gets ACK and sets status bit 1.
- R8: With NAK-OUT mode on, an acknowledged short OUT packet sets the NAK-OUT latch.
- R9: `ev_tx` pulses for one cycle after a packet or zero-length packet is sent and acknowledged. `ev_rx` pulses after an OUT packet is acknowledged. While hide-status is set, neither pulses for status-phase tokens.
- R10: A 1 written to the status clear port clears that status bit. A hardware set in the same cycle wins.
- R11: The response appears one cycle after the token is accepted. A token is accepted only when `tok_ready` is high, that is, when no response is held or the held one is taken that cycle. A held response keeps its values until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_set_we | input | 1 | Set-port write strobe |
| ctl_set_bits | input | 8 | Bits to set |
| ctl_clr_we | input | 1 | Clear-port write strobe |
| ctl_clr_bits | input | 8 | Bits to clear |
| ctl_q | output | 8 | Current control word |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_bits | input | 6 | Status bits to clear |
| stat_q | output | 6 | Outcome status |
| tok_valid | input | 1 | Token beat valid |
| tok_ready | output | 1 | Token beat accepted |
| tok_kind | input | 2 | 0 setup, 1 OUT, 2 IN |
| tok_status | input | 1 | Token belongs to the status phase |
| tok_err | input | 1 | IN: no host ACK; OUT: corrupt packet |
| tok_short | input | 1 | OUT packet shorter than max size |
| buf_full | input | 1 | Buffer holds a full max-size packet |
| buf_commit | input | 1 | IN buffer validated by software |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Response beat taken |
| rsp_hs | output | 3 | Handshake code |
| rsp_data_odd | output | 1 | PID parity of sent data |
| ev_rx | output | 1 | Data-received pulse |
| ev_tx | output | 1 | Data-transmitted pulse |

## Verification
The selection logic is driven with setup, status-phase and data tokens of both directions. Each is tried with halt, the status hold, the NAK-OUT latch and a full buffer set and then cleared, so each priority level can be told apart. IN tokens are tried with an empty buffer, a full buffer with and without auto-validate, and a committed buffer. With and without host acknowledge, they separate the ACK-driven toggle from interrupt-feedback toggling. Set/clear collisions, status clears that meet a hardware set, and a held response with a blocked second token show the edge rules.

// File: rtl/ep_rsp_pkg.sv
package ep_rsp_pkg;
  localparam int CTL_W  = 8;
  localparam int STAT_W = 6;

  // control word bit positions
  localparam int C_HALT = 0;
  localparam int C_TOG  = 1;
  localparam int C_NMOD = 2;
  localparam int C_HOLD = 3;
  localparam int C_INTR = 4;
  localparam int C_AUTO = 5;
  localparam int C_HIDE = 6;
  localparam int C_NLAT = 7;

  // status bit positions
  localparam int S_TMO   = 0;
  localparam int S_OACK  = 1;
  localparam int S_ONAK  = 2;
  localparam int S_IACK  = 3;
  localparam int S_INAK  = 4;
  localparam int S_STALL = 5;

  localparam logic [CTL_W-1:0] CTL_RESET = 8'h20;

  typedef enum logic [1:0] {TK_SETUP = 2'd0, TK_OUT = 2'd1, TK_IN = 2'd2, TK_BAD = 2'd3} tok_kind_e;
  typedef enum logic [2:0] {
    HS_ACK = 3'd0, HS_NAK = 3'd1, HS_STALL = 3'd2,
    HS_ZLP = 3'd3, HS_DATA = 3'd4, HS_NONE = 3'd5
  } hs_e;
  typedef enum logic [1:0] {TG_KEEP = 2'd0, TG_FLIP = 2'd1, TG_ONE = 2'd2} tog_op_e;

  typedef struct packed {
    hs_e               hs;
    logic              odd;
    logic [STAT_W-1:0] stat_set;
    tog_op_e           tog;
    logic              latch_set;
    logic              hold_set;
    logic              halt_clr;
    logic              ev_rx;
    logic              ev_tx;
  } decision_t;
endpackage

// File: rtl/ep_rsp_decide.sv
module ep_rsp_decide
  import ep_rsp_pkg::*;
#(
  parameter bit IS_EP0 = 1'b1
) (
  input  logic [CTL_W-1:0] ctl,
  input  tok_kind_e        kind,
  input  logic             status,
  input  logic             err,
  input  logic             short_pkt,
  input  logic             buf_full,
  input  logic             buf_commit,
  output decision_t        d
);
  logic sendable;
  logic hide;

  assign sendable = buf_commit || (ctl[C_AUTO] && buf_full);
  assign hide     = ctl[C_HIDE];

  always_comb begin
    d = '0;
    d.hs = HS_NONE;
    d.tog = TG_KEEP;
    if (kind == TK_SETUP) begin
      d.hs = HS_ACK;
      d.stat_set[S_OACK] = 1'b1;
      d.tog = TG_ONE;
      d.hold_set = IS_EP0;
      d.halt_clr = IS_EP0;
    end else if (kind == TK_BAD) begin
      d.hs = HS_NONE;
    end else if (ctl[C_HALT]) begin
      d.hs = HS_STALL;
      d.stat_set[S_STALL] = 1'b1;
    end else if (status) begin
      if (ctl[C_HOLD]) begin
        d.hs = HS_NAK;
        if (kind == TK_IN) d.stat_set[S_INAK] = 1'b1;
        else               d.stat_set[S_ONAK] = 1'b1;
      end else if (kind == TK_OUT) begin
        d.hs = HS_ACK;
        d.stat_set[S_OACK] = 1'b1;
        d.ev_rx = !hide;
      end else begin
        d.hs = HS_ZLP;
        d.odd = 1'b1;
        if (err) d.stat_set[S_TMO]  = 1'b1;
        else     d.stat_set[S_IACK] = 1'b1;
        d.ev_tx = !err && !hide;
      end
    end else if (kind == TK_IN) begin
      if (!sendable) begin
        d.hs = HS_NAK;
        d.stat_set[S_INAK] = 1'b1;
      end else begin
        d.hs = HS_DATA;
        d.odd = ctl[C_TOG];
        if (err) d.stat_set[S_TMO]  = 1'b1;
        else     d.stat_set[S_IACK] = 1'b1;
        d.ev_tx = !err;
        d.tog = (!err || ctl[C_INTR]) ? TG_FLIP : TG_KEEP;
      end
    end else begin
      if (ctl[C_NLAT] || buf_full) begin
        d.hs = HS_NAK;
        d.stat_set[S_ONAK] = 1'b1;
      end else if (err) begin
        d.hs = HS_NONE;
        d.stat_set[S_TMO] = 1'b1;
      end else begin
        d.hs = HS_ACK;
        d.stat_set[S_OACK] = 1'b1;
        d.ev_rx = 1'b1;
        d.tog = TG_FLIP;
        d.latch_set = ctl[C_NMOD] && short_pkt;
      end
    end
  end
endmodule

// File: rtl/ep_rsp_ctlreg.sv
module ep_rsp_ctlreg
  import ep_rsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic [CTL_W-1:0] set_bits,
  input  logic             clr_we,
  input  logic [CTL_W-1:0] clr_bits,
  input  logic             hw_en,
  input  decision_t        d,
  output logic [CTL_W-1:0] q
);
  logic [CTL_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (clr_we) nxt = nxt & ~clr_bits;
    if (set_we) nxt = nxt | set_bits;
    if (hw_en) begin
      if (d.latch_set) nxt[C_NLAT] = 1'b1;
      if (d.hold_set)  nxt[C_HOLD] = 1'b1;
      if (d.halt_clr)  nxt[C_HALT] = 1'b0;
      case (d.tog)
        TG_FLIP: nxt[C_TOG] = ~q[C_TOG];
        TG_ONE:  nxt[C_TOG] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= CTL_RESET;
    else        q <= nxt;
  end
endmodule

// File: rtl/ep_rsp_w1c.sv
module ep_rsp_w1c #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hw_set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                   q[i] <= 1'b0;
      else if (hw_set[i])           q[i] <= 1'b1;
      else if (clr_we && clr_bits[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_rsp_ctrl.sv
module ep_rsp_ctrl
  import ep_rsp_pkg::*;
#(
  parameter bit IS_EP0 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_set_we,
  input  logic [7:0]        ctl_set_bits,
  input  logic              ctl_clr_we,
  input  logic [7:0]        ctl_clr_bits,
  output logic [7:0]        ctl_q,
  input  logic              stat_clr_we,
  input  logic [5:0]        stat_clr_bits,
  output logic [5:0]        stat_q,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [1:0]        tok_kind,
  input  logic              tok_status,
  input  logic              tok_err,
  input  logic              tok_short,
  input  logic              buf_full,
  input  logic              buf_commit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_hs,
  output logic              rsp_data_odd,
  output logic              ev_rx,
  output logic              ev_tx
);
  decision_t         dec;
  logic              acc;
  logic [STAT_W-1:0] stat_hw;

  assign tok_ready = !rsp_valid || rsp_ready;
  assign acc       = tok_valid && tok_ready;
  assign stat_hw   = acc ? dec.stat_set : '0;

  ep_rsp_decide #(.IS_EP0(IS_EP0)) u_dec (
    .ctl(ctl_q), .kind(tok_kind_e'(tok_kind)), .status(tok_status),
    .err(tok_err), .short_pkt(tok_short), .buf_full(buf_full),
    .buf_commit(buf_commit), .d(dec)
  );

  ep_rsp_ctlreg u_ctl (
    .clk(clk), .rst_n(rst_n), .set_we(ctl_set_we), .set_bits(ctl_set_bits),
    .clr_we(ctl_clr_we), .clr_bits(ctl_clr_bits), .hw_en(acc), .d(dec), .q(ctl_q)
  );

  ep_rsp_w1c #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .hw_set(stat_hw), .clr_we(stat_clr_we),
    .clr_bits(stat_clr_bits), .q(stat_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hs       <= HS_NONE;
      rsp_data_odd <= 1'b0;
      ev_rx        <= 1'b0;
      ev_tx        <= 1'b0;
    end else begin
      ev_rx <= acc && dec.ev_rx;
      ev_tx <= acc && dec.ev_tx;
      if (acc) begin
        rsp_valid    <= 1'b1;
        rsp_hs       <= dec.hs;
        rsp_data_odd <= dec.odd;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ep_rsp_ctrl_chk.sv
module ep_rsp_ctrl_chk #(
  parameter bit IS_EP0 = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_set_we,
  input logic [7:0] ctl_set_bits,
  input logic [7:0] ctl_q,
  input logic       stat_clr_we,
  input logic [5:0] stat_clr_bits,
  input logic [5:0] stat_q,
  input logic       tok_valid,
  input logic       tok_ready,
  input logic [1:0] tok_kind,
  input logic       tok_status,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [2:0] rsp_hs,
  input logic       rsp_data_odd
);
  logic accepted;
  assign accepted = tok_valid && tok_ready;

  assert_set_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set_we && ctl_set_bits[2]) |=> ctl_q[2]);

  assert_halt_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && tok_kind != 2'd0 && tok_kind != 2'd3 && ctl_q[0]) |=> (rsp_hs == 3'd2 && stat_q[5]));

  if (IS_EP0) begin : g_ep0
    assert_setup_ep0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && tok_kind == 2'd0) |=> (ctl_q[3] && !ctl_q[0] && ctl_q[1] && rsp_hs == 3'd0));
  end

  assert_nak_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && tok_kind == 2'd1 && !tok_status && !ctl_q[0] && ctl_q[7]) |=> (rsp_hs == 3'd1));

  assert_stat_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[5] && !(stat_clr_we && stat_clr_bits[5])) |=> stat_q[5]);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hs) && $stable(rsp_data_odd)));
endmodule

bind ep_rsp_ctrl ep_rsp_ctrl_chk #(.IS_EP0(IS_EP0)) chk_i (.*);

// File: tb/ep_rsp_ctrl_tb_top.sv
module ep_rsp_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_set_we = 0, ctl_clr_we = 0, stat_clr_we = 0;
  logic [7:0] ctl_set_bits = 0, ctl_clr_bits = 0;
  logic [5:0] stat_clr_bits = 0;
  logic [7:0] ctl_q;
  logic [5:0] stat_q;
  logic tok_valid = 0, tok_status = 0, tok_err = 0, tok_short = 0;
  logic [1:0] tok_kind = 0;
  logic buf_full = 0, buf_commit = 0, rsp_ready = 1;
  logic tok_ready, rsp_valid, rsp_data_odd, ev_rx, ev_tx;
  logic [2:0] rsp_hs;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ep_rsp_ctrl dut_i (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [7:0] s, logic [7:0] c);
    ctl_set_we = (s != 0); ctl_set_bits = s;
    ctl_clr_we = (c != 0); ctl_clr_bits = c;
    @(negedge clk);
    ctl_set_we = 0; ctl_clr_we = 0;
  endtask

  task automatic clr_stat();
    stat_clr_we = 1; stat_clr_bits = 6'h3F;
    @(negedge clk);
    stat_clr_we = 0;
  endtask

  task automatic send(logic [1:0] k, logic st, logic er, logic sh);
    tok_kind = k; tok_status = st; tok_err = er; tok_short = sh; tok_valid = 1;
    @(negedge clk);
    tok_valid = 0; tok_status = 0; tok_err = 0; tok_short = 0;
  endtask

  task automatic t_reset();
    check("R1 reset ctl", ctl_q, 8'h20);
    check("R10 reset stat", stat_q, 0);
    check("R11 reset rsp_valid", rsp_valid, 0);
    check("R11 reset tok_ready", tok_ready, 1);
  endtask

  task automatic t_setclr();
    wr_ctl(8'h14, 0);    check("R1 set", ctl_q, 8'h34);
    wr_ctl(0, 8'h20);    check("R1 clear", ctl_q, 8'h14);
    wr_ctl(8'h04, 8'h04); check("R1 set wins", ctl_q, 8'h14);
    wr_ctl(0, 8'h14);    check("R1 clear two", ctl_q, 8'h00);
    wr_ctl(8'h20, 0);    check("R1 restore", ctl_q, 8'h20);
  endtask

  task automatic t_setup();
    wr_ctl(8'h01, 0);
    send(2'd0, 0, 0, 0);
    check("R3 setup ack", rsp_hs, 0);
    check("R3 setup ctl", ctl_q, 8'h2A);
    check("R3 setup stat", stat_q, 6'h02);
  endtask

  task automatic t_status();
    send(2'd2, 1, 0, 0);
    check("R4 hold IN nak", rsp_hs, 1);
    check("R4 hold IN stat", stat_q, 6'h12);
    send(2'd1, 1, 0, 0);
    check("R4 hold OUT nak", rsp_hs, 1);
    check("R4 hold OUT stat", stat_q, 6'h16);
    wr_ctl(0, 8'h08);
    send(2'd2, 1, 0, 0);
    check("R4 status IN zlp", rsp_hs, 3);
    check("R4 zlp parity", rsp_data_odd, 1);
    check("R9 zlp ev_tx", ev_tx, 1);
    send(2'd1, 1, 0, 0);
    check("R4 status OUT ack", rsp_hs, 0);
    check("R9 status ev_rx", ev_rx, 1);
    wr_ctl(8'h40, 0);
    send(2'd1, 1, 0, 0);
    check("R9 hidden ev_rx", ev_rx, 0);
    send(2'd2, 1, 0, 0);
    check("R9 hidden ev_tx", ev_tx, 0);
    check("R9 hidden zlp", rsp_hs, 3);
    wr_ctl(0, 8'h40);
    check("R4 toggle kept", ctl_q, 8'h22);
    clr_stat();
    check("R10 clear all", stat_q, 0);
  endtask

  task automatic t_halt();
    wr_ctl(8'h01, 0);
    send(2'd2, 0, 0, 0);
    check("R2 IN stall", rsp_hs, 2);
    check("R2 stall stat", stat_q, 6'h20);
    send(2'd1, 0, 0, 0);
    check("R2 OUT stall", rsp_hs, 2);
    wr_ctl(0, 8'h01);
    clr_stat();
  endtask

  task automatic t_in();
    wr_ctl(0, 8'h02);
    stat_clr_we = 1; stat_clr_bits = 6'h10;
    send(2'd2, 0, 0, 0);
    stat_clr_we = 0;
    check("R5 empty nak", rsp_hs, 1);
    check("R10 hw set wins", stat_q, 6'h10);
    buf_full = 1;
    send(2'd2, 0, 0, 0);
    check("R5 auto data", rsp_hs, 4);
    check("R5 parity0", rsp_data_odd, 0);
    check("R6 ack flip", ctl_q, 8'h22);
    check("R9 data ev_tx", ev_tx, 1);
    check("R6 in ack stat", stat_q, 6'h18);
    wr_ctl(0, 8'h20);
    send(2'd2, 0, 0, 0);
    check("R5 no auto nak", rsp_hs, 1);
    buf_commit = 1;
    send(2'd2, 0, 0, 0);
    check("R5 commit data", rsp_hs, 4);
    check("R5 parity1", rsp_data_odd, 1);
    check("R6 flip back", ctl_q, 8'h00);
    send(2'd2, 0, 1, 0);
    check("R6 no ack keep", ctl_q, 8'h00);
    check("R6 timeout stat", stat_q[0], 1);
    check("R9 no ack ev_tx", ev_tx, 0);
    wr_ctl(8'h10, 0);
    send(2'd2, 0, 1, 0);
    check("R6 intr flip", ctl_q, 8'h12);
    wr_ctl(0, 8'h10);
    wr_ctl(8'h20, 0);
    buf_full = 0; buf_commit = 0;
    clr_stat();
  endtask

  task automatic t_out();
    send(2'd1, 0, 0, 0);
    check("R7 out ack", rsp_hs, 0);
    check("R6 out flip", ctl_q, 8'h20);
    check("R9 out ev_rx", ev_rx, 1);
    check("R7 out stat", stat_q, 6'h02);
    send(2'd1, 0, 1, 0);
    check("R7 corrupt none", rsp_hs, 5);
    check("R7 corrupt stat", stat_q, 6'h03);
    buf_full = 1;
    send(2'd1, 0, 0, 0);
    check("R7 full nak", rsp_hs, 1);
    check("R7 nak stat", stat_q, 6'h07);
    buf_full = 0;
    wr_ctl(8'h04, 0);
    send(2'd1, 0, 0, 1);
    check("R8 short ack", rsp_hs, 0);
    check("R8 latch set", ctl_q, 8'hA6);
    send(2'd1, 0, 0, 0);
    check("R7 latch nak", rsp_hs, 1);
    check("R7 latch ctl", ctl_q, 8'hA6);
    wr_ctl(0, 8'h80);
    send(2'd1, 0, 0, 0);
    check("R7 unlatched ack", rsp_hs, 0);
    check("R7 unlatched ctl", ctl_q, 8'h24);
    clr_stat();
  endtask

  task automatic t_bp();
    rsp_ready = 0;
    send(2'd1, 0, 0, 0);
    check("R11 held valid", rsp_valid, 1);
    check("R11 not ready", tok_ready, 0);
    tok_kind = 2'd2; tok_valid = 1;
    @(negedge clk);
    check("R11 held hs", rsp_hs, 0);
    check("R11 blocked ctl", ctl_q, 8'h26);
    check("R11 blocked stat", stat_q, 6'h02);
    tok_valid = 0; rsp_ready = 1;
    @(negedge clk);
    check("R11 drained", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setclr();
    t_setup();
    t_status();
    t_halt();
    t_in();
    t_out();
    t_bp();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule